// File: doc/BRIEF.md
# Timed-Access Write Guard

This unit sits beside a processor's special-register write bus and protects six critical control bits against stray writes. It watches every bus write (address, data, strobe) that lands on an enabled machine cycle. Software must first write the byte AAh and then the byte 55h to a dedicated key address, C7h, on two back-to-back machine cycles. That opens a short window in which one write to a guarded bit may take effect. All other bits in the same registers are not affected by the window.

The six guarded bits live inside the unit. Four are in the watchdog-control register: the power-on flag (bit 6), the watchdog interrupt flag (bit 3), the watchdog reset enable (bit 1) and the watchdog restart (bit 0). One is the band-gap select in the control register (bit 0). One is bit 2 of the memory-size register. For each bus write the unit also gives a per-bit write mask, which the surrounding register file uses to qualify its own unprotected bits. The register addresses are parameters. The key address is fixed by default at C7h.

Top module: `ta_guard`

## Requirements
- R1: After reset the power-on flag reads 1, the other five guarded bits read 0, and the window is closed.
- R2: The window opens only after a write of AAh to the key address (default C7h), followed on the very next enabled cycle by a write of 55h to the same address.
- R3: Once opened, the window stays open for the three enabled cycles that follow the 55h write, and it is closed on the fourth.
- R4: A write to a guarded register while the window is closed leaves every guarded bit at its old value.
- R5: A write to a guarded register while the window is open loads the guarded bits from the data byte. In the watchdog-control register these are bit 6 to the power-on flag, bit 3 to the interrupt flag, bit 1 to the reset enable and bit 0 to the restart bit. Bit 0 loads the band-gap select and bit 2 loads the memory-size bit.
- R6: A write accepted into a guarded register closes the window at once. A second write in what would have been the same window is ignored.
- R7: After AAh, any enabled cycle that is not a write of 55h or AAh to the key address sends the detector back to idle. This includes a key write of another value and a cycle with no write. A repeated AAh re-arms the detector.
- R8: `wr_mask` has a 1 at every unprotected bit position for every address. Its protected positions (watchdog-control 4Bh, control 01h, memory-size 04h) are 1 only while the window is open.
- R9: The watchdog restart bit reads 1 for exactly one clock after an accepted write that sets it, and then clears itself.
- R10: On cycles with `cyc_en` low the write strobe is ignored and neither the window count nor the key detector changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle enable; only enabled cycles count |
| bus_we | input | 1 | Special-register write strobe |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| wr_mask | output | 8 | Per-bit write permission for the current bus write |
| win_open | output | 1 | Unlock window is open |
| por_flag | output | 1 | Guarded power-on flag |
| wdt_irq_flag | output | 1 | Guarded watchdog interrupt flag |
| wdt_rst_en | output | 1 | Guarded watchdog reset enable |
| wdt_restart | output | 1 | Guarded, self-clearing watchdog restart |
| bandgap_sel | output | 1 | Guarded band-gap select |
| memsz_b2 | output | 1 | Guarded memory-size bit 2 |

## Verification
The assertions assume that the key address differs from the three guarded register addresses, so a key write and a guarded write can never occur on the same cycle. They also assume that the bus inputs are stable around each clock edge. The stimulus only uses the default addresses, and it changes the bus inputs on the falling edge only. It includes stalled cycles with `cyc_en` low both inside and outside a window, so that the hold rules are exercised with legal bus values.

// File: rtl/ta_guard.sv
module ta_guard #(
  parameter logic [7:0] KEY_ADDR = 8'hC7,
  parameter logic [7:0] WDC_ADDR = 8'hD8,
  parameter logic [7:0] CTL_ADDR = 8'h85,
  parameter logic [7:0] MSZ_ADDR = 8'hC2,
  parameter logic [7:0] KEY_FIRST = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55,
  parameter int unsigned WIN_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] wr_mask,
  output logic       win_open,
  output logic       por_flag,
  output logic       wdt_irq_flag,
  output logic       wdt_rst_en,
  output logic       wdt_restart,
  output logic       bandgap_sel,
  output logic       memsz_b2
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [7:0] WDC_PM = 8'h4B;
  localparam logic [7:0] CTL_PM = 8'h01;
  localparam logic [7:0] MSZ_PM = 8'h04;

  logic          seq_aa;
  logic [CW-1:0] win_cnt;
  logic [7:0]    pmask;

  wire wr      = cyc_en && bus_we;
  wire key_wr  = wr && (bus_addr == KEY_ADDR);
  wire key_hit = key_wr && seq_aa && (bus_wdata == KEY_SECOND);
  wire acc     = wr && win_open && (pmask != 8'h00);

  assign win_open = (win_cnt != '0);

  always_comb begin
    case (bus_addr)
      WDC_ADDR: pmask = WDC_PM;
      CTL_ADDR: pmask = CTL_PM;
      MSZ_ADDR: pmask = MSZ_PM;
      default:  pmask = 8'h00;
    endcase
  end

  assign wr_mask = win_open ? 8'hFF : ~pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_aa <= 1'b0;
    else if (cyc_en) seq_aa <= key_wr && (bus_wdata == KEY_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (key_hit) win_cnt <= CW'(WIN_LEN);
    else if (acc) win_cnt <= '0;
    else if (cyc_en && win_open) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_flag     <= 1'b1;
      wdt_irq_flag <= 1'b0;
      wdt_rst_en   <= 1'b0;
      wdt_restart  <= 1'b0;
      bandgap_sel  <= 1'b0;
      memsz_b2     <= 1'b0;
    end else begin
      wdt_restart <= 1'b0;
      if (acc && bus_addr == WDC_ADDR) begin
        por_flag     <= bus_wdata[6];
        wdt_irq_flag <= bus_wdata[3];
        wdt_rst_en   <= bus_wdata[1];
        wdt_restart  <= bus_wdata[0];
      end
      if (acc && bus_addr == CTL_ADDR) bandgap_sel <= bus_wdata[0];
      if (acc && bus_addr == MSZ_ADDR) memsz_b2 <= bus_wdata[2];
    end
  end

  p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(key_hit));

  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !win_open) |=> $stable({por_flag, wdt_irq_flag, wdt_rst_en, bandgap_sel, memsz_b2}));

  p_close_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !win_open);

  p_restart_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_restart |=> !wdt_restart);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(win_cnt) && $stable(seq_aa)));

  p_unprot_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> ((wr_mask & pmask) == 8'h00));
endmodule

// File: tb/ta_guard_tb.sv
`timescale 1ns/100ps
module ta_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cyc_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] wr_mask;
  logic win_open, por_flag, wdt_irq_flag, wdt_rst_en, wdt_restart, bandgap_sel, memsz_b2;

  always #2.5 clk = ~clk;

  ta_guard dut_i (.clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_mask(wr_mask), .win_open(win_open),
    .por_flag(por_flag), .wdt_irq_flag(wdt_irq_flag), .wdt_rst_en(wdt_rst_en),
    .wdt_restart(wdt_restart), .bandgap_sel(bandgap_sel), .memsz_b2(memsz_b2));

  typedef struct { logic [7:0] mask; logic [5:0] bits; logic win; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic       m_aa = 1'b0;
  int         m_cnt = 0;
  logic [5:0] m_bits = 6'b100000;

  function automatic logic [7:0] pm(input logic [7:0] a);
    case (a)
      8'hD8: return 8'h4B;
      8'h85: return 8'h01;
      8'hC2: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic en, input logic we, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
    item_t it;
    logic wr, acc, hit;
    @(negedge clk);
    cyc_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    it.mask = (m_cnt != 0) ? 8'hFF : ~pm(a);
    it.bits = m_bits; it.win = (m_cnt != 0); it.tag = tag;
    q.push_back(it);
    wr  = en && we;
    hit = wr && a == 8'hC7 && d == 8'h55 && m_aa;
    acc = wr && m_cnt != 0 && pm(a) != 8'h00;
    m_bits[2] = 1'b0;
    if (acc && a == 8'hD8) m_bits[5:2] = {d[6], d[3], d[1], d[0]};
    if (acc && a == 8'h85) m_bits[1] = d[0];
    if (acc && a == 8'hC2) m_bits[0] = d[2];
    if (hit) m_cnt = 3;
    else if (acc) m_cnt = 0;
    else if (en && m_cnt != 0) m_cnt = m_cnt - 1;
    if (en) m_aa = wr && a == 8'hC7 && d == 8'hAA;
  endtask

  task automatic idle(input string tag); step(1'b1, 1'b0, 8'h00, 8'h00, tag); endtask
  task automatic unlock(input string tag);
    step(1'b1, 1'b1, 8'hC7, 8'hAA, tag);
    step(1'b1, 1'b1, 8'hC7, 8'h55, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() != 0) begin
        item_t it;
        logic [5:0] got;
        it = q.pop_front();
        got = {por_flag, wdt_irq_flag, wdt_rst_en, wdt_restart, bandgap_sel, memsz_b2};
        checks++;
        if (got !== it.bits || wr_mask !== it.mask || win_open !== it.win) begin
          fails++;
          $display("FAIL %s: bits=%b mask=%h win=%b expected bits=%b mask=%h win=%b",
                   it.tag, got, wr_mask, win_open, it.bits, it.mask, it.win);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    step(1, 1, 8'hD8, 8'hFF, "R4 R8 locked watchdog write");
    step(1, 1, 8'h85, 8'hFF, "R4 locked control write");
    step(1, 1, 8'h10, 8'hFF, "R8 unrelated address mask");
    unlock("R2 unlock");
    step(1, 1, 8'hD8, 8'h0B, "R5 R9 watchdog write in window");
    step(1, 1, 8'hD8, 8'h40, "R6 second write after accept");
    idle("R9 restart cleared");
    unlock("R3 unlock");
    idle("R3 open 1"); idle("R3 open 2"); idle("R3 open 3");
    step(1, 1, 8'h85, 8'h01, "R3 write after window");
    idle("R3 check");
    unlock("R3 unlock b");
    idle("R3 b1"); idle("R3 b2");
    step(1, 1, 8'h85, 8'h01, "R3 R5 last window cycle");
    idle("R5 bandgap set");
    step(1, 1, 8'hC7, 8'hAA, "R7 aa");
    step(1, 1, 8'hC7, 8'h56, "R7 wrong second byte");
    step(1, 1, 8'hC7, 8'h55, "R7 late 55");
    step(1, 1, 8'hC2, 8'h04, "R7 no window");
    step(1, 1, 8'hC7, 8'hAA, "R7 aa gap");
    idle("R7 gap");
    step(1, 1, 8'hC7, 8'h55, "R7 55 after gap");
    step(1, 1, 8'hC2, 8'h04, "R7 still locked");
    step(1, 1, 8'hC7, 8'hAA, "R7 aa");
    step(1, 1, 8'hC7, 8'hAA, "R7 aa repeat");
    step(1, 1, 8'hC7, 8'h55, "R7 re-armed 55");
    step(0, 1, 8'hC2, 8'h04, "R10 stalled write");
    step(0, 0, 8'h00, 8'h00, "R10 stall"); step(0, 0, 8'h00, 8'h00, "R10 stall");
    step(0, 0, 8'h00, 8'h00, "R10 stall"); step(0, 0, 8'h00, 8'h00, "R10 stall");
    step(1, 1, 8'hC2, 8'h04, "R10 R5 write after stalls");
    idle("R5 memsize set");
    step(1, 1, 8'hC7, 8'hAA, "R10 aa");
    step(0, 0, 8'h00, 8'h00, "R10 stall between keys");
    step(1, 1, 8'hC7, 8'h55, "R10 55 after stall");
    step(1, 1, 8'hD8, 8'h4A, "R5 R8 watchdog load");
    idle("R5 final"); idle("R9 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule